// File: doc/BRIEF.md
# I/O Privilege and Permission Bitmap Checker

This block decides whether an operation that is sensitive to the I/O privilege level may run. A request gives the current privilege level, the 2-bit I/O privilege field from the flags register, a flag that says whether the task uses the 16-bit or the 32-bit task state segment format, an operation class, and, for port operations, the port number and access size.

When the current level is privileged enough, the request is allowed at once. When it is not, a task using the 16-bit format faults. Under the 32-bit format, non-port operations fault, but port operations are decided from the task's I/O permission bitmap. The block fetches up to two bitmap bytes over a request/acknowledge read port and tests every port the access covers.

Each accepted request ends in a single done pulse. That pulse carries exactly one verdict, either allow or fault.

Top module: `io_perm_gate`

## Requirements
- R1: When `req_cpl` <= `req_iopl` (unsigned), an accepted request of any operation class gets `res_done` with `res_allow` in the cycle after acceptance, and no memory read is made.
- R2: When `req_cpl` > `req_iopl` and `req_wide_tss` is 0 (16-bit format), the request gets `res_done` with `res_fault` in the cycle after acceptance, with no memory read.
- R3: When `req_cpl` > `req_iopl` and `req_wide_tss` is 1, the non-port classes get `res_done` with `res_fault` in the cycle after acceptance, with no memory read. These classes are `req_op` 0 (interrupt flag clear), 1 (interrupt flag set), 2 (write of the interrupt-enable flag) and 7 (reserved).
- R4: When `req_cpl` > `req_iopl` and `req_wide_tss` is 1, the port classes are decided from the bitmap. These classes are `req_op` 3 (port in), 4 (port out), 5 (string port in) and 6 (string port out). Port p maps to bit p mod 8 of the byte at `map_base` + p/8. A set bit denies the port and a clear bit permits it.
- R5: `req_size` 0, 1 and 2 cover 1, 2 and 4 consecutive ports starting at `req_port`, and 3 also covers 4 ports. The access is allowed only if the bits of all covered ports are clear.
- R6: When the covered bits reach into the next byte, a second read is made at the first byte's address plus one. The second read is skipped if the first byte already denies the access.
- R7: A bitmap byte whose address is greater than `map_limit` counts as denying the access and is never read.
- R8: Every accepted request produces exactly one `res_done` pulse with exactly one of `res_allow` and `res_fault` high. Both are low whenever `res_done` is low.
- R9: `mem_req` stays high with `mem_addr` stable until `mem_ack`, whatever the latency. `res_done` follows in the cycle after the last needed acknowledge.
- R10: After reset, `req_ready` is 1, and `res_done`, `res_allow`, `res_fault` and `mem_req` are 0.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low while a bitmap read is in progress. A new request may be accepted in the same cycle that the previous verdict is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege field from the flags register |
| req_wide_tss | input | 1 | 1 = 32-bit task segment format, 0 = 16-bit |
| req_op | input | 3 | Operation class (see R3, R4) |
| req_port | input | PORT_W | First port number |
| req_size | input | 2 | Access size code (see R5) |
| map_base | input | ADDR_W | Byte address of the bitmap start |
| map_limit | input | ADDR_W | Highest valid bitmap byte address |
| mem_req | output | 1 | Bitmap read request |
| mem_addr | output | ADDR_W | Bitmap byte address |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 8 | Bitmap byte read |
| res_done | output | 1 | Verdict pulse |
| res_allow | output | 1 | Operation permitted |
| res_fault | output | 1 | General protection fault |

## Verification
Two things can fall in the same clock edge: one request's verdict going out and the next request being accepted. The bench provokes this by holding `req_valid` high with fresh operands, so a request that privilege settles is followed at once by another. It also issues a bitmap request right after a verdict. A scoreboard queue, filled in request order, then expects one verdict per pulse with no lost or merged pulses. It also matches the number of memory acknowledges seen since the previous pulse against the reads the model predicts, under memory latencies of zero, three and a rotating value.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [2:0] {
    OPC_IF_CLR   = 3'd0,
    OPC_IF_SET   = 3'd1,
    OPC_IF_WRITE = 3'd2,
    OPC_PORT_IN  = 3'd3,
    OPC_PORT_OUT = 3'd4,
    OPC_STR_IN   = 3'd5,
    OPC_STR_OUT  = 3'd6,
    OPC_RSVD     = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2
  } gate_st_e;

  function automatic logic is_port_op(input op_class_e op);
    return (op == OPC_PORT_IN) || (op == OPC_PORT_OUT) ||
           (op == OPC_STR_IN)  || (op == OPC_STR_OUT);
  endfunction

endpackage

// File: rtl/io_priv_decide.sv
module io_priv_decide
  import io_perm_pkg::*;
(
  input  logic [1:0] cpl,
  input  logic [1:0] iopl,
  input  logic       wide_tss,
  input  op_class_e  op,
  output logic       grant,
  output logic       need_map
);
  // Lower number means more privileged.
  assign grant    = (cpl <= iopl);
  assign need_map = !grant && wide_tss && is_port_op(op);
endmodule

// File: rtl/io_span_calc.sv
module io_span_calc #(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        size_code,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [ADDR_W-1:0] addr_hi,
  output logic [7:0]        mask_lo,
  output logic [7:0]        mask_hi,
  output logic              spans_two,
  output logic              lo_ok,
  output logic              hi_ok
);
  localparam int IDX_W = PORT_W - 3;

  logic [3:0]        run_bits;
  logic [15:0]       span;
  logic [IDX_W-1:0]  byte_idx;

  always_comb begin
    unique case (size_code)
      2'd0:    run_bits = 4'b0001;
      2'd1:    run_bits = 4'b0011;
      default: run_bits = 4'b1111;
    endcase
  end

  assign span      = {12'b0, run_bits} << port[2:0];
  assign mask_lo   = span[7:0];
  assign mask_hi   = span[15:8];
  assign spans_two = |mask_hi;

  assign byte_idx = port[PORT_W-1:3];
  assign addr_lo  = base + ADDR_W'(byte_idx);
  assign addr_hi  = addr_lo + ADDR_W'(1);
  assign lo_ok    = (addr_lo <= limit);
  assign hi_ok    = (addr_hi <= limit);
endmodule

// File: rtl/io_perm_gate.sv
module io_perm_gate
  import io_perm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_iopl,
  input  logic              req_wide_tss,
  input  logic [2:0]        req_op,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] map_base,
  input  logic [ADDR_W-1:0] map_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_data,
  output logic              res_done,
  output logic              res_allow,
  output logic              res_fault
);
  gate_st_e          st, st_nx;
  logic              grant, need_map;
  logic [ADDR_W-1:0] addr_lo, addr_hi, addr_hi_q;
  logic [7:0]        mask_lo, mask_hi, mask_lo_q, mask_hi_q;
  logic              spans_two, lo_ok, hi_ok, two_q, hi_ok_q;
  logic              accept, fin, fin_ok, start_rd, go_hi;

  io_priv_decide u_priv (
    .cpl      (req_cpl),
    .iopl     (req_iopl),
    .wide_tss (req_wide_tss),
    .op       (op_class_e'(req_op)),
    .grant    (grant),
    .need_map (need_map)
  );

  io_span_calc #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_span (
    .port      (req_port),
    .size_code (req_size),
    .base      (map_base),
    .limit     (map_limit),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .spans_two (spans_two),
    .lo_ok     (lo_ok),
    .hi_ok     (hi_ok)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_nx    = st;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    start_rd = 1'b0;
    go_hi    = 1'b0;
    unique case (st)
      ST_IDLE: if (accept) begin
        if (grant) begin
          fin = 1'b1; fin_ok = 1'b1;
        end else if (!need_map || !lo_ok) begin
          fin = 1'b1;
        end else begin
          start_rd = 1'b1; st_nx = ST_RD_LO;
        end
      end
      ST_RD_LO: if (mem_ack) begin
        if (|(mem_data & mask_lo_q)) begin
          fin = 1'b1; st_nx = ST_IDLE;
        end else if (!two_q) begin
          fin = 1'b1; fin_ok = 1'b1; st_nx = ST_IDLE;
        end else if (!hi_ok_q) begin
          fin = 1'b1; st_nx = ST_IDLE;
        end else begin
          go_hi = 1'b1; st_nx = ST_RD_HI;
        end
      end
      ST_RD_HI: if (mem_ack) begin
        fin = 1'b1; fin_ok = !(|(mem_data & mask_hi_q)); st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      res_done  <= 1'b0;
      res_allow <= 1'b0;
      res_fault <= 1'b0;
      addr_hi_q <= '0;
      mask_lo_q <= '0;
      mask_hi_q <= '0;
      two_q     <= 1'b0;
      hi_ok_q   <= 1'b0;
    end else begin
      st        <= st_nx;
      res_done  <= fin;
      res_allow <= fin && fin_ok;
      res_fault <= fin && !fin_ok;
      if (start_rd) begin
        mem_req   <= 1'b1;
        mem_addr  <= addr_lo;
        addr_hi_q <= addr_hi;
        mask_lo_q <= mask_lo;
        mask_hi_q <= mask_hi;
        two_q     <= spans_two;
        hi_ok_q   <= hi_ok;
      end else if (go_hi) begin
        mem_addr <= addr_hi_q;
      end else if (fin) begin
        mem_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/io_perm_gate_chk.sv
module io_perm_gate_chk #(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_cpl,
  input logic [1:0]        req_iopl,
  input logic              req_wide_tss,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] map_limit,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              res_done,
  input logic              res_allow,
  input logic              res_fault
);
  logic acc, port_cls;
  assign acc      = req_valid && req_ready;
  assign port_cls = (req_op >= 3'd3) && (req_op <= 3'd6);

  // R1
  grant_fast_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (req_cpl <= req_iopl) |=> res_done && res_allow && !mem_req);

  // R2
  narrow_fault_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (req_cpl > req_iopl) && !req_wide_tss |=> res_done && res_fault && !mem_req);

  // R3
  nonport_fault_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (req_cpl > req_iopl) && req_wide_tss && !port_cls |=> res_done && res_fault && !mem_req);

  // R7
  limit_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr <= map_limit);

  // R8
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |-> (res_allow != res_fault));

  // R8
  quiet_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !res_done |-> !res_allow && !res_fault);

  // R9
  hold_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

bind io_perm_gate io_perm_gate_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cpl      (req_cpl),
  .req_iopl     (req_iopl),
  .req_wide_tss (req_wide_tss),
  .req_op       (req_op),
  .map_limit    (map_limit),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .res_done     (res_done),
  .res_allow    (res_allow),
  .res_fault    (res_fault)
);

// File: tb/tb_io_perm_gate.sv
module tb_io_perm_gate;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W = 16;
  localparam int ADDR_W = 32;
  localparam logic [ADDR_W-1:0] MAP_BASE = 32'h100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_cpl = '0, req_iopl = '0, req_size = '0;
  logic              req_wide_tss = 1'b0;
  logic [2:0]        req_op = '0;
  logic [PORT_W-1:0] req_port = '0;
  logic [ADDR_W-1:0] map_base = MAP_BASE;
  logic [ADDR_W-1:0] map_limit = MAP_BASE + 7;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ack = 1'b0;
  logic [7:0]        mem_data = '0;
  logic              res_done, res_allow, res_fault;

  int   vectors = 0, fails = 0;
  int   ack_total = 0, ack_mark = 0, wait_cnt = 0, lat = 0;
  bit   lat_rot = 0;
  bit   finished = 0;
  logic [7:0] bm [0:63];

  bit    exp_ok_q [$];
  int    exp_rd_q [$];
  string exp_tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  io_perm_gate #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cpl(req_cpl), .req_iopl(req_iopl), .req_wide_tss(req_wide_tss),
    .req_op(req_op), .req_port(req_port), .req_size(req_size),
    .map_base(map_base), .map_limit(map_limit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .res_done(res_done), .res_allow(res_allow), .res_fault(res_fault)
  );

  function automatic logic [7:0] byte_at(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - MAP_BASE;
    if (a >= MAP_BASE && off < 64) return bm[off[5:0]];
    return 8'hFF;
  endfunction

  // Memory model with variable latency.
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; wait_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_cnt >= (lat_rot ? (ack_total % 3) : lat)) begin
        mem_ack   <= 1'b1;
        mem_data  <= byte_at(mem_addr);
        wait_cnt  <= 0;
        ack_total <= ack_total + 1;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    vectors++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic model(input logic [1:0] cpl, input logic [1:0] iopl, input bit wide,
                       input logic [2:0] op, input int port, input logic [1:0] sz,
                       output bit ok, output int rd);
    int n;
    logic [ADDR_W-1:0] a;
    n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    rd = 0;
    ok = 1;
    if (cpl <= iopl) return;
    if (!wide || op < 3'd3 || op > 3'd6) begin ok = 0; return; end
    for (int b = port / 8; b <= (port + n - 1) / 8; b++) begin
      a = map_base + ADDR_W'(b);
      if (a > map_limit) begin ok = 0; return; end
      rd++;
      for (int p = port; p < port + n; p++)
        if (p / 8 == b && byte_at(a)[p % 8]) begin ok = 0; return; end
    end
  endtask

  task automatic send(input logic [1:0] cpl, input logic [1:0] iopl, input bit wide,
                      input logic [2:0] op, input int port, input logic [1:0] sz,
                      input string tag);
    bit ok; int rd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cpl = cpl; req_iopl = iopl; req_wide_tss = wide; req_op = op;
    req_port = PORT_W'(port); req_size = sz; req_valid = 1'b1;
    model(cpl, iopl, wide, op, port, sz, ok, rd);
    exp_ok_q.push_back(ok); exp_rd_q.push_back(rd); exp_tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_ok_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) check(!req_ready, "R11 ready low during read", req_ready, 0);
      if (res_done) begin
        if (exp_ok_q.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          bit ok; int rd; string tag;
          ok = exp_ok_q.pop_front(); rd = exp_rd_q.pop_front(); tag = exp_tag_q.pop_front();
          check(res_allow == ok, {tag, " allow"}, res_allow, ok);
          check(res_fault == !ok, "R8 fault is complement of allow", res_fault, !ok);
          check(ack_total - ack_mark == rd, {tag, " R6 R7 read count"}, ack_total - ack_mark, rd);
          ack_mark = ack_total;
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) bm[i] = 8'h00;
    bm[1] = 8'h80;   // port 15
    bm[2] = 8'h01;   // port 16
    bm[4] = 8'h10;   // port 36
    bm[6] = 8'h02;   // port 49
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 ready", req_ready, 1);
    check(res_done == 1'b0, "R10 done", res_done, 0);
    check(res_allow == 1'b0 && res_fault == 1'b0, "R10 verdict", {res_allow, res_fault}, 0);
    check(mem_req == 1'b0, "R10 mem_req", mem_req, 0);

    // R1 privilege settles, back-to-back (R11 accept while verdict shown)
    send(2'd0, 2'd0, 1'b0, 3'd0, 0, 2'd0, "R1 cli equal");
    send(2'd1, 2'd3, 1'b1, 3'd3, 15, 2'd0, "R1 port in privileged");
    send(2'd3, 2'd3, 1'b0, 3'd6, 16, 2'd2, "R1 string out");
    // R2 narrow format
    send(2'd3, 2'd0, 1'b0, 3'd4, 8, 2'd0, "R2 port out narrow");
    send(2'd1, 2'd0, 1'b0, 3'd1, 0, 2'd0, "R2 sti narrow");
    // R3 non-port under wide format
    send(2'd3, 2'd1, 1'b1, 3'd0, 8, 2'd0, "R3 cli wide");
    send(2'd2, 2'd1, 1'b1, 3'd2, 8, 2'd0, "R3 if write wide");
    send(2'd3, 2'd0, 1'b1, 3'd7, 8, 2'd0, "R3 reserved wide");
    drain();

    // R4/R5 single-byte bitmap checks, zero latency
    lat = 0;
    send(2'd3, 2'd0, 1'b1, 3'd3, 8, 2'd0, "R4 clear bit");
    send(2'd3, 2'd0, 1'b1, 3'd4, 15, 2'd0, "R4 set bit");
    send(2'd3, 2'd0, 1'b1, 3'd5, 12, 2'd1, "R5 two ports clear");
    send(2'd3, 2'd0, 1'b1, 3'd6, 12, 2'd2, "R5 four ports last denied");
    send(2'd3, 2'd0, 1'b1, 3'd3, 8, 2'd3, "R5 size code 3");
    send(2'd3, 2'd0, 1'b1, 3'd3, 17, 2'd2, "R5 neighbour bit not covered");
    send(2'd3, 2'd1, 1'b0, 3'd0, 0, 2'd0, "R2 after bitmap read");
    drain();

    // R6 crossing, latency 3
    lat = 3;
    send(2'd3, 2'd0, 1'b1, 3'd3, 6, 2'd2, "R6 cross clear");
    send(2'd3, 2'd0, 1'b1, 3'd4, 7, 2'd1, "R6 cross two ports");
    send(2'd3, 2'd0, 1'b1, 3'd3, 14, 2'd1, "R6 first byte denies");
    send(2'd3, 2'd0, 1'b1, 3'd3, 13, 2'd2, "R6 first byte denies wide");
    send(2'd3, 2'd0, 1'b1, 3'd4, 46, 2'd2, "R6 second byte denies");
    send(2'd3, 2'd0, 1'b1, 3'd5, 30, 2'd2, "R6 cross not covered");
    send(2'd3, 2'd0, 1'b1, 3'd6, 34, 2'd2, "R4 inside byte denied");
    drain();

    // R7 limit, rotating latency
    lat_rot = 1;
    send(2'd3, 2'd0, 1'b1, 3'd3, 64, 2'd0, "R7 first byte beyond limit");
    send(2'd3, 2'd0, 1'b1, 3'd3, 62, 2'd2, "R7 second byte beyond limit");
    send(2'd3, 2'd0, 1'b1, 3'd4, 57, 2'd1, "R7 last byte inside");
    send(2'd0, 2'd0, 1'b1, 3'd3, 200, 2'd0, "R1 beyond limit but privileged");
    send(2'd3, 2'd2, 1'b1, 3'd3, 65535, 2'd2, "R7 top port");
    drain();
    @(negedge clk);
    map_limit = MAP_BASE + 63;
    send(2'd3, 2'd0, 1'b1, 3'd3, 62, 2'd2, "R6 wider limit cross");
    send(2'd3, 2'd0, 1'b1, 3'd3, 504, 2'd0, "R4 last mapped byte");
    drain();

    repeat (4) @(negedge clk);
    check(res_done == 1'b0 && exp_ok_q.size() == 0, "R8 no extra done", res_done, 0);
    summary();
  end
endmodule